// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This unit sits beside the register file of a 16550-style serial port and decides which single interrupt the port reports. Each cycle it looks at five candidate sources: receive line errors, a receive character timeout, received data, an empty transmit holding register, and modem status changes. It masks each source with the software enable bits, ranks the survivors and registers the result as the identification byte and the interrupt request line.

The unit owns two pieces of state. One is the four-bit enable register. The other is the "transmitter empty" pending flag, which needs its own memory because reading the identification byte clears it while the holding register stays empty. The FIFOs, the timers and the shift registers live elsewhere. They feed this unit with levels and single-cycle pulses.

Top module: `uart_irq_ident`

## Requirements
- R1: A write to the enable register (`ier_wr_i`) keeps only `ier_wdata_i[3:0]`; the stored value appears on `ier_o` after the write edge. Bit 0 enables received data and timeout, bit 1 the transmitter empty source, bit 2 line status, bit 3 modem status.
- R2: When enable bit 2 is set and any of `lsr_i[4:1]` is set, the identification code (`iir_o[3:0]`) is 0x6, regardless of every other source.
- R3: When enable bit 0 and `cto_pend_i` are set and no line-status interrupt applies, the code is 0xC, ahead of received data.
- R4: With `fifo_en_i` high, received data (code 0x4) needs `lsr_i[0]` and `rx_count_i` at or above the trigger level chosen by `trig_sel_i`: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14 entries.
- R5: With `fifo_en_i` low, `lsr_i[0]` with enable bit 0 alone gives code 0x4, whatever the count.
- R6: A `thre_set_i` pulse, or an enable write while `thre_lvl_i` is high, sets the transmitter-empty pending flag. When enable bit 1 is set, that flag yields code 0x2 if nothing higher is pending.
- R7: A read strobe `iir_rd_i` or a holding-register write `thr_wr_i` clears the pending flag. A set in the same cycle wins over a clear.
- R8: When enable bit 3 is set and any of `msr_delta_i` is set, with nothing higher pending, the code is 0x0.
- R9: With no enabled source active, the code is 0x1.
- R10: `iir_o[7:6]` read 11 while `fifo_en_i` is high and 00 otherwise; `iir_o[5:4]` are always 0.
- R11: `irq_o` is high exactly when `out2_i` was high and `iir_o[0]` is 0.
- R12: After reset, `iir_o` is 0x01, `irq_o` is 0 and `ier_o` is 0. All outputs follow their inputs one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| iir_rd_i | input | 1 | Identification byte read strobe |
| thr_wr_i | input | 1 | Holding register write strobe |
| thre_set_i | input | 1 | Holding register became empty (pulse) |
| thre_lvl_i | input | 1 | Holding register currently empty (level) |
| lsr_i | input | 5 | Line status: bit 0 data ready, bits 4:1 error and break flags |
| rx_count_i | input | CNT_W (5) | Receive FIFO occupancy |
| trig_sel_i | input | 2 | Receive trigger level select |
| fifo_en_i | input | 1 | FIFOs enabled |
| cto_pend_i | input | 1 | Character timeout pending |
| msr_delta_i | input | 4 | Modem status delta flags |
| out2_i | input | 1 | Interrupt output gate from modem control |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request |
| ier_o | output | 4 | Stored enable register |

## Verification
The hardest situation to reach is a collision on the pending flag: an identification read or holding-register write in the same cycle as a fresh empty event. The bench drives `iir_rd_i` together with `thre_set_i` in one cycle and checks that code 0x2 survives. The trigger thresholds are probed one entry below and exactly at each of the four levels. Each priority pair is tested by holding the lower source active while the higher one is toggled.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IER_W = 4;
  localparam int NSRC  = 5;

  // enable bit positions (software-visible, fixed)
  localparam int IE_RXD = 0;
  localparam int IE_THR = 1;
  localparam int IE_LSR = 2;
  localparam int IE_MSR = 3;

  localparam logic [3:0] ID_NONE = 4'h1;

  // source index 0 is the highest priority
  localparam logic [3:0] SRC_ID [NSRC] = '{4'h6, 4'hC, 4'h4, 4'h2, 4'h0};
endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int CNT_W = 5,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14
) (
  input  logic             fifo_en,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] count,
  input  logic             data_rdy,
  output logic             rx_ready
);
  localparam logic [CNT_W-1:0] LVL [4] = '{LVL0[CNT_W-1:0], LVL1[CNT_W-1:0],
                                           LVL2[CNT_W-1:0], LVL3[CNT_W-1:0]};
  logic [CNT_W-1:0] level;
  logic             at_level;

  always_comb begin
    level    = LVL[sel];
    at_level = (count >= level);
    rx_ready = data_rdy && (!fifo_en || at_level);
  end
endmodule

// File: rtl/uart_irq_thri.sv
module uart_irq_thri
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  input  logic             iir_rd,
  input  logic             thr_wr,
  input  logic             thre_set,
  input  logic             thre_lvl,
  output logic [IER_W-1:0] ier_d,
  output logic [IER_W-1:0] ier_q,
  output logic             pend_d,
  output logic             pend_q
);
  logic arm;
  logic disarm;

  always_comb begin
    ier_d  = ier_wr ? ier_wdata[IER_W-1:0] : ier_q;
    arm    = thre_set || (ier_wr && thre_lvl);
    disarm = iir_rd || thr_wr;
    pend_d = pend_q;
    if (arm)
      pend_d = 1'b1;
    else if (disarm)
      pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (ier_wr)
        ier_q <= ier_d;
      if (arm || disarm)
        pend_q <= pend_d;
    end
  end

  AST_IER_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> (ier_q == $past(ier_wdata[IER_W-1:0]))); // R1
  AST_THR_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && thre_lvl) |=> pend_q); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && !thre_set && !(ier_wr && thre_lvl)) |=> !pend_q); // R7
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] src,
  output logic [3:0]      code
);
  always_comb begin
    code = ID_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (src[i])
        code = SRC_ID[i];
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr_i,
  input  logic [7:0]       ier_wdata_i,
  input  logic             iir_rd_i,
  input  logic             thr_wr_i,
  input  logic             thre_set_i,
  input  logic             thre_lvl_i,
  input  logic [4:0]       lsr_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             fifo_en_i,
  input  logic             cto_pend_i,
  input  logic [3:0]       msr_delta_i,
  input  logic             out2_i,
  output logic [7:0]       iir_o,
  output logic             irq_o,
  output logic [IER_W-1:0] ier_o
);
  logic [IER_W-1:0] ier_d, ier_q;
  logic             pend_d, pend_q;
  logic             rx_ready;
  logic [NSRC-1:0]  src;
  logic [3:0]       code;
  logic [7:0]       iir_d, iir_q;
  logic             irq_d, irq_q;

  uart_irq_thri u_thri (
    .clk      (clk),
    .rst_n    (rst_n),
    .ier_wr   (ier_wr_i),
    .ier_wdata(ier_wdata_i),
    .iir_rd   (iir_rd_i),
    .thr_wr   (thr_wr_i),
    .thre_set (thre_set_i),
    .thre_lvl (thre_lvl_i),
    .ier_d    (ier_d),
    .ier_q    (ier_q),
    .pend_d   (pend_d),
    .pend_q   (pend_q)
  );

  uart_irq_trig #(.CNT_W(CNT_W)) u_trig (
    .fifo_en (fifo_en_i),
    .sel     (trig_sel_i),
    .count   (rx_count_i),
    .data_rdy(lsr_i[0]),
    .rx_ready(rx_ready)
  );

  always_comb begin
    src[0] = ier_d[IE_LSR] && (|lsr_i[4:1]);
    src[1] = ier_d[IE_RXD] && cto_pend_i;
    src[2] = ier_d[IE_RXD] && rx_ready;
    src[3] = ier_d[IE_THR] && pend_d;
    src[4] = ier_d[IE_MSR] && (|msr_delta_i);
  end

  uart_irq_prio u_prio (
    .src (src),
    .code(code)
  );

  always_comb begin
    iir_d = {{2{fifo_en_i}}, 2'b00, code};
    irq_d = out2_i && !code[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iir_q <= {4'h0, ID_NONE};
      irq_q <= 1'b0;
    end else begin
      iir_q <= iir_d;
      irq_q <= irq_d;
    end
  end

  assign iir_o = iir_q;
  assign irq_o = irq_q;
  assign ier_o = ier_q;

  AST_LSR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ier_wr_i && ier_q[IE_LSR] && (|lsr_i[4:1])) |=> (iir_o[3:0] == 4'h6)); // R2
  AST_MSR_ENCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ier_wr_i && ier_q == 4'b1000 && (|msr_delta_i)) |=> (iir_o[3:0] == 4'h0)); // R8
  AST_FIFO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (iir_o[7:6] == {2{$past(fifo_en_i)}}) && (iir_o[5:4] == 2'b00)); // R10
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == ($past(out2_i) && !iir_o[0]))); // R11
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ier_wr_i && ier_q == '0) |=> (iir_o[3:0] == 4'h1)); // R9
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ier_wr_i;
  logic [7:0]       ier_wdata_i;
  logic             iir_rd_i;
  logic             thr_wr_i;
  logic             thre_set_i;
  logic             thre_lvl_i;
  logic [4:0]       lsr_i;
  logic [CNT_W-1:0] rx_count_i;
  logic [1:0]       trig_sel_i;
  logic             fifo_en_i;
  logic             cto_pend_i;
  logic [3:0]       msr_delta_i;
  logic             out2_i;
  logic [7:0]       iir_o;
  logic             irq_o;
  logic [3:0]       ier_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  uart_irq_ident u_dut (
    .clk(clk), .rst_n(rst_n), .ier_wr_i(ier_wr_i), .ier_wdata_i(ier_wdata_i),
    .iir_rd_i(iir_rd_i), .thr_wr_i(thr_wr_i), .thre_set_i(thre_set_i),
    .thre_lvl_i(thre_lvl_i), .lsr_i(lsr_i), .rx_count_i(rx_count_i),
    .trig_sel_i(trig_sel_i), .fifo_en_i(fifo_en_i), .cto_pend_i(cto_pend_i),
    .msr_delta_i(msr_delta_i), .out2_i(out2_i), .iir_o(iir_o), .irq_o(irq_o),
    .ier_o(ier_o)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_wr_i = 1'b1; ier_wdata_i = v;
    cyc();
    ier_wr_i = 1'b0;
  endtask

  task automatic quiet();
    lsr_i = '0; rx_count_i = '0; trig_sel_i = '0; fifo_en_i = 1'b0;
    cto_pend_i = 1'b0; msr_delta_i = '0; thre_lvl_i = 1'b0;
    iir_rd_i = 1'b0; thr_wr_i = 1'b0; thre_set_i = 1'b0;
    wr_ier(8'h00);
    cyc();
  endtask

  task automatic t_reset();
    check("R12 iir reset", iir_o, 8'h01);
    check("R12 irq reset", {7'b0, irq_o}, 8'h00);
    check("R12 ier reset", {4'b0, ier_o}, 8'h00);
  endtask

  task automatic t_ier_mask();
    wr_ier(8'hF5);
    check("R1 upper bits dropped", {4'b0, ier_o}, 8'h05);
    quiet();
  endtask

  task automatic t_lsr();
    wr_ier(8'h0F);
    lsr_i = 5'b00101; cto_pend_i = 1'b1; msr_delta_i = 4'h3;
    cyc();
    check("R2 line status beats all", iir_o, 8'h06);
    check("R11 irq with out2", {7'b0, irq_o}, 8'h01);
    wr_ier(8'h0B);
    check("R2 needs enable bit", iir_o, 8'h0C);
    quiet();
  endtask

  task automatic t_timeout();
    wr_ier(8'h01);
    lsr_i = 5'b00001; cto_pend_i = 1'b1;
    cyc();
    check("R3 timeout over rx data", iir_o, 8'h0C);
    wr_ier(8'h00);
    check("R3 gated by bit0", iir_o, 8'h01);
    quiet();
  endtask

  task automatic t_trig();
    logic [4:0] lv [4];
    lv[0] = 5'd1; lv[1] = 5'd4; lv[2] = 5'd8; lv[3] = 5'd14;
    wr_ier(8'h01);
    fifo_en_i = 1'b1; lsr_i = 5'b00001;
    for (int s = 0; s < 4; s++) begin
      trig_sel_i = s[1:0];
      rx_count_i = lv[s] - 5'd1;
      cyc();
      check("R4 below level", iir_o, 8'hC1);
      rx_count_i = lv[s];
      cyc();
      check("R4 at level", iir_o, 8'hC4);
    end
    check("R10 fifo tag set", {iir_o[7:4], 4'h0}, 8'hC0);
    quiet();
  endtask

  task automatic t_nofifo();
    wr_ier(8'h01);
    lsr_i = 5'b00001; rx_count_i = '0; trig_sel_i = 2'b11;
    cyc();
    check("R5 data ready alone", iir_o, 8'h04);
    check("R10 fifo tag clear", {iir_o[7:4], 4'h0}, 8'h00);
    quiet();
  endtask

  task automatic t_thre();
    wr_ier(8'h02);
    check("R9 nothing pending", iir_o, 8'h01);
    thre_set_i = 1'b1; cyc(); thre_set_i = 1'b0;
    check("R6 set by pulse", iir_o, 8'h02);
    thr_wr_i = 1'b1; cyc(); thr_wr_i = 1'b0;
    check("R7 cleared by thr write", iir_o, 8'h01);
    thre_lvl_i = 1'b1;
    wr_ier(8'h02);
    check("R6 rearm on enable write", iir_o, 8'h02);
    thre_lvl_i = 1'b0;
    iir_rd_i = 1'b1; cyc(); iir_rd_i = 1'b0;
    check("R7 cleared by read", iir_o, 8'h01);
    iir_rd_i = 1'b1; thre_set_i = 1'b1; cyc();
    iir_rd_i = 1'b0; thre_set_i = 1'b0;
    check("R7 set wins over read", iir_o, 8'h02);
    iir_rd_i = 1'b1; cyc(); iir_rd_i = 1'b0;
    quiet();
  endtask

  task automatic t_msr();
    wr_ier(8'h08);
    msr_delta_i = 4'b0100;
    #1;
    check("R12 one edge latency", iir_o, 8'h01);
    cyc();
    check("R8 modem code", iir_o, 8'h00);
    check("R11 irq high", {7'b0, irq_o}, 8'h01);
    out2_i = 1'b0;
    cyc();
    check("R11 irq gated by out2", {7'b0, irq_o}, 8'h00);
    check("R8 code kept without out2", iir_o, 8'h00);
    out2_i = 1'b1;
    quiet();
  endtask

  initial begin
    rst_n = 1'b0; out2_i = 1'b1;
    ier_wr_i = 1'b0; ier_wdata_i = '0; iir_rd_i = 1'b0; thr_wr_i = 1'b0;
    thre_set_i = 1'b0; thre_lvl_i = 1'b0; lsr_i = '0; rx_count_i = '0;
    trig_sel_i = '0; fifo_en_i = 1'b0; cto_pend_i = 1'b0; msr_delta_i = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_ier_mask();
    t_lsr();
    t_timeout();
    t_trig();
    t_nofifo();
    t_thre();
    t_msr();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule